// File: doc/BRIEF.md
# Tiled Wide Significand Multiplier

This block multiplies two 53-bit unsigned significands and returns the full 106-bit product. Each significand is assembled from a 52-bit fraction input and a per-operand flag that supplies the leading bit: a set flag marks a normalized operand, and a clear flag marks a subnormal one. The block is meant to sit inside a double-width floating-point multiply datapath. Sign, exponent, normalization, rounding and exception logic sit around it and are not part of it.

The product is never formed by one wide multiplier. Operand A is cut into the slices [23:0], [40:24] and [52:41]. Operand B is cut into the slices [16:0], [33:17], [50:34] and [52:51]. Each of the twelve slice pairs is at most 24 by 17 unsigned bits, which fits a small 25x18 signed hardware multiplier tile. The first pipeline stage registers the narrow partial products. The second stage shifts each partial product left by the sum of its two slice low-bit indices, adds them all, and registers the sum.

An input strobe yields an output strobe exactly two cycles later. A new operand pair may be accepted on every cycle.

Top module: `sig_tile_mul`

## Requirements
- R1: When out_valid_o is high, prod_o equals {hid_a_i, frac_a_i} * {hid_b_i, frac_b_i} as an exact unsigned 106-bit product of the operands accepted two cycles earlier.
- R2: out_valid_o is high exactly two clock cycles after a cycle in which in_valid_i was sampled high, and low otherwise. Back-to-back inputs produce back-to-back results in the same order.
- R3: A clear hid_a_i or hid_b_i makes bit 52 of that significand zero, so the product is formed from the fraction alone.
- R4: If either significand is zero, the product delivered for that pair is zero.
- R5: When both hidden flags are set, at least one of prod_o[105:104] is 1. When both are clear, prod_o[105:104] is 2'b00.
- R6: While rst_ni is low, and after it is released until the first result, out_valid_o is 0 and prod_o is zero.
- R7: prod_o keeps its value in every cycle in which out_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair present this cycle |
| frac_a_i | input | 52 | Fraction of operand A |
| hid_a_i | input | 1 | Leading significand bit of operand A |
| frac_b_i | input | 52 | Fraction of operand B |
| hid_b_i | input | 1 | Leading significand bit of operand B |
| out_valid_o | output | 1 | Product present this cycle |
| prod_o | output | 106 | Full significand product |

## Verification
The bench drives all-ones fractions, where every tile and every carry between tile offsets is live. A wrong slice offset or a truncated partial product would then show as a wrong high half. It also drives operands with a clear hidden flag, where a hard-wired leading one would inflate the product by a whole shifted operand. Zero operands are driven too, where a stale register would leak an earlier product. Random pairs arrive in bursts and with gaps. A design with the wrong latency, a dropped strobe, or an output that drifts while idle shows up as a queue mismatch or a changed held value.

// File: rtl/sig_tile_pkg.sv
package sig_tile_pkg;
  localparam int FRAC_W = 52;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int TILE_AW = 24;
  localparam int TILE_BW = 17;
  localparam int PP_W   = TILE_AW + TILE_BW;
  localparam int NA = 3;
  localparam int NB = 4;
  localparam int NT = NA * NB;
  localparam int A_LO [NA] = '{0, 24, 41};
  localparam int A_WD [NA] = '{24, 17, 12};
  localparam int B_LO [NB] = '{0, 17, 34, 51};
  localparam int B_WD [NB] = '{17, 17, 17, 2};

  function automatic int tile_shift(input int t);
    return A_LO[t / NB] + B_LO[t % NB];
  endfunction
endpackage

// File: rtl/sig_tile_pp.sv
module sig_tile_pp #(
  parameter int AW = 24,
  parameter int BW = 17,
  localparam int OW = AW + BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic [OW-1:0] pp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pp_o <= '0;
    else if (en_i) pp_o <= OW'(a_i) * OW'(b_i);
  end

  // R7: the tile register only moves on an accepted input
  p_tile_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(pp_o));
endmodule

// File: rtl/sig_tile_sum.sv
module sig_tile_sum
  import sig_tile_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic [NT-1:0][PP_W-1:0]  pp_i,
  output logic [PROD_W-1:0]        sum_o
);
  logic [PROD_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int t = 0; t < NT; t++) begin
      acc = acc + (PROD_W'(pp_i[t]) << tile_shift(t));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sum_o <= '0;
    else if (en_i) sum_o <= acc;
  end

  p_sum_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(sum_o));
endmodule

// File: rtl/sig_tile_mul.sv
module sig_tile_mul
  import sig_tile_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  input  logic [FRAC_W-1:0]   frac_a_i,
  input  logic                hid_a_i,
  input  logic [FRAC_W-1:0]   frac_b_i,
  input  logic                hid_b_i,
  output logic                out_valid_o,
  output logic [PROD_W-1:0]   prod_o
);
  logic [SIG_W-1:0] sig_a, sig_b;
  logic [NT-1:0][PP_W-1:0] pp_all;
  logic v1_q, v2_q;

  assign sig_a = {hid_a_i, frac_a_i};
  assign sig_b = {hid_b_i, frac_b_i};

  for (genvar i = 0; i < NA; i++) begin : g_a
    for (genvar j = 0; j < NB; j++) begin : g_b
      localparam int AW = A_WD[i];
      localparam int BW = B_WD[j];
      logic [AW+BW-1:0] pp_n;
      sig_tile_pp #(.AW(AW), .BW(BW)) i_tile (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (in_valid_i),
        .a_i   (sig_a[A_LO[i] +: AW]),
        .b_i   (sig_b[B_LO[j] +: BW]),
        .pp_o  (pp_n)
      );
      assign pp_all[i*NB+j] = PP_W'(pp_n);
    end
  end

  sig_tile_sum i_sum (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (v1_q),
    .pp_i  (pp_all),
    .sum_o (prod_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= in_valid_i;
      v2_q <= v1_q;
    end
  end
  assign out_valid_o = v2_q;

  // R2: strobe appears two cycles after the input strobe
  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> ##1 out_valid_o);
  p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ##1 !out_valid_o);
  // R4: zero significand gives zero product
  p_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (sig_a == '0 || sig_b == '0)) |=> ##1 (prod_o == '0));
  // R5: top bits follow the hidden flags
  p_top_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && hid_a_i && hid_b_i) |=> ##1 (prod_o[PROD_W-1 -: 2] != 2'b00));
  p_top_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !hid_a_i && !hid_b_i) |=> ##1 (prod_o[PROD_W-1 -: 2] == 2'b00));
  // R7: output held while idle
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(prod_o));
endmodule

// File: tb/test_sig_tile_mul.sv
module test_sig_tile_mul;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [51:0] frac_a = '0, frac_b = '0;
  logic hid_a = 1'b0, hid_b = 1'b0;
  logic out_valid;
  logic [105:0] prod;

  always #5 clk = ~clk;

  sig_tile_mul i_sig_tile_mul (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid),
    .frac_a_i(frac_a), .hid_a_i(hid_a), .frac_b_i(frac_b), .hid_b_i(hid_b),
    .out_valid_o(out_valid), .prod_o(prod)
  );

  typedef struct {
    logic [105:0] exp_p;
    int           due;
    string        tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit done = 0;
  logic [105:0] last_p = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [105:0] act, input logic [105:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp_v);
    end
  endtask

  // driver: called at negedge, presents one pair for the next posedge
  task automatic drive(input logic ha, input logic [51:0] fa, input logic hb, input logic [51:0] fb, input string tag);
    item_t it;
    logic [105:0] ea, eb;
    ea = {53'd0, ha, fa};
    eb = {53'd0, hb, fb};
    it.exp_p = ea * eb;
    it.due = cyc + 2;
    it.tag = tag;
    q.push_back(it);
    in_valid = 1'b1; hid_a = ha; frac_a = fa; hid_b = hb; frac_b = fb;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R2 unexpected strobe", prod, '0);
        end else begin
          item_t it;
          it = q.pop_front();
          check(prod == it.exp_p, it.tag, prod, it.exp_p);
          check(cyc == it.due, "R2 latency", 106'(cyc), 106'(it.due));
          if (it.exp_p >= (106'd1 << 104))
            check(prod[105:104] != 2'b00, "R5 top bits", prod, it.exp_p);
        end
      end else begin
        check(prod == last_p, "R7 hold", prod, last_p);
      end
      last_p = prod;
    end
  end

  initial begin
    logic [51:0] ones;
    ones = '1;
    idle(2);
    check(out_valid == 1'b0, "R6 valid in reset", 106'(out_valid), '0);
    check(prod == '0, "R6 prod in reset", prod, '0);
    rst_n = 1'b1;
    idle(2);
    check(out_valid == 1'b0 && prod == '0, "R6 after release", prod, '0);
    drive(1, ones, 1, ones, "R1 all ones");
    drive(0, ones, 0, ones, "R3 R5 both hidden clear");
    drive(0, ones, 1, ones, "R3 one hidden clear");
    drive(1, '0, 1, ones, "R1 unit times max");
    drive(0, '0, 1, ones, "R4 zero a");
    drive(1, ones, 0, '0, "R4 zero b");
    idle(3);
    drive(0, 52'd1, 0, 52'd1, "R3 smallest");
    drive(1, 52'h8_0000_0000_0001, 1, 52'h0_0000_0002_0001, "R1 sparse bits");
    idle(1);
    for (int k = 0; k < 300; k++) begin
      drive(1'($urandom), {20'($urandom), 32'($urandom)},
            1'($urandom), {20'($urandom), 32'($urandom)}, "R1 random");
      if ($urandom_range(3) == 0) idle($urandom_range(3));
    end
    idle(5);
    check(q.size() == 0, "R2 all results returned", 106'(q.size()), '0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule